// File: doc/BRIEF.md
# Arithmetic Status Flag Unit

This block adds or subtracts two 32-bit operands at a chosen width of 8, 16 or 32 bits and works out the arithmetic status flags of that operation. The result, masked to the chosen width, appears on the output in the same cycle as the inputs. The six arithmetic flags are captured into a 32-bit flags word on the rising clock edge of a cycle in which the update strobe is high.

Three control bits share the same word: trap, interrupt enable and string direction. A separate write port loads them. The direction bit is also driven out as a step-sign signal, which tells string pointer logic whether to count down.

Carry, sign and overflow follow the selected width. Auxiliary carry always comes from bit 3, and parity always comes from the low byte, at every width.

Top module: `status_flag_unit`

## Requirements
- R1: `result` holds the low W bits of `op_a + op_b + carry_in`, or of `op_a - op_b - carry_in` when `sub` is 1. All result bits at and above W are 0, and operand bits above W have no effect. The width code `width_sel` maps 00 to W=8, 01 to W=16, and 10 or 11 to W=32.
- R2: Carry, at flags bit 0, is set on a carry out of bit W-1 for an add, or on a borrow into bit W-1 for a subtract.
- R3: Overflow, at flags bit 11, is set when the carry or borrow into bit W-1 differs from the carry or borrow out of that bit.
- R4: Sign, at flags bit 7, equals result bit W-1.
- R5: Zero, at flags bit 6, is set only when every bit of the masked result is 0.
- R6: Auxiliary carry, at flags bit 4, is set on a carry out of bit 3 for an add, or a borrow into bit 3 for a subtract, at every width.
- R7: Parity, at flags bit 2, is 1 when `result[7:0]` holds an even number of ones and 0 when the count is odd, at every width.
- R8: The arithmetic flag bits change only on a rising edge where `update` is 1. With `update` and `ctl_we` both 0, the whole flags word holds.
- R9: On a rising edge where `ctl_we` is 1, flags bits 8 (trap), 9 (interrupt enable) and 10 (direction) load `ctl_wdata[0]`, `ctl_wdata[1]` and `ctl_wdata[2]`. The arithmetic bits still load from `update` in the same cycle.
- R10: `step_dec` equals flags bit 10. A value of 1 means string pointers decrement, and 0 means they increment.
- R11: Flags bit 1 always reads 1. Bits 3, 5 and 12 to 31 always read 0.
- R12: A synchronous reset (`rst` high at a rising edge) sets the flags word to 0x00000002.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| carry_in | input | 1 | Carry (add) or borrow (subtract) input |
| sub | input | 1 | 1 selects subtract, 0 selects add |
| width_sel | input | 2 | Operation width code |
| update | input | 1 | Capture the arithmetic flags at this edge |
| ctl_we | input | 1 | Write the control bits at this edge |
| ctl_wdata | input | 3 | {direction, interrupt enable, trap} |
| result | output | 32 | Width-masked result |
| flags | output | 32 | Registered flags word |
| step_dec | output | 1 | String pointer step sign (1 means decrement) |

## Verification
A flag capture and a control-bit write can land on the same rising edge. Both touch the flags register, but they own separate bits. The bench drives `update` and `ctl_we` together in directed steps and in the random run. For each such cycle its model loads the six arithmetic bits from the operation and bits 8 to 10 from `ctl_wdata`, and the monitor then compares the whole registered word and `step_dec` one edge later.

// File: rtl/flagunit_pkg.sv
`timescale 1ns/1ps
package flagunit_pkg;

  localparam int DATA_W = 32;
  localparam int FLAG_W = 32;

  localparam int CF_POS  = 0;
  localparam int ONE_POS = 1;
  localparam int PF_POS  = 2;
  localparam int AF_POS  = 4;
  localparam int ZF_POS  = 6;
  localparam int SF_POS  = 7;
  localparam int TF_POS  = 8;
  localparam int IE_POS  = 9;
  localparam int DIR_POS = 10;
  localparam int OF_POS  = 11;

  typedef enum logic [1:0] {
    W8   = 2'b00,
    W16  = 2'b01,
    W32  = 2'b10,
    W32X = 2'b11
  } width_e;

  typedef struct packed {
    logic ovf;
    logic sgn;
    logic zer;
    logic aux;
    logic par;
    logic cry;
  } arith_flags_t;

  // Keeps the low 8, 16 or 32 bits.
  function automatic logic [DATA_W-1:0] width_mask(width_e w);
    case (w)
      W8:      return {{(DATA_W-8){1'b0}}, 8'hFF};
      W16:     return {{(DATA_W-16){1'b0}}, 16'hFFFF};
      default: return {DATA_W{1'b1}};
    endcase
  endfunction

  // Index of the sign bit for the selected width.
  function automatic logic [4:0] top_index(width_e w);
    case (w)
      W8:      return 5'd7;
      W16:     return 5'd15;
      default: return 5'd31;
    endcase
  endfunction

  function automatic logic even_parity8(logic [7:0] v);
    return ~^v;
  endfunction

endpackage

// File: rtl/fu_arith.sv
`timescale 1ns/1ps
module fu_arith
  import flagunit_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          cin,
  input  logic          sub,
  input  width_e        width,
  output logic [DW-1:0] res,
  output logic          carry_into_top,
  output logic          carry_out_top,
  output logic          aux_carry
);

  logic [DW-1:0] msk;
  logic [DW-1:0] am;
  logic [DW-1:0] bm;
  logic [DW:0]   wide;
  logic [4:0]    nib;
  logic [4:0]    tidx;
  logic [5:0]    cidx;

  always_comb begin
    msk  = width_mask(width);
    am   = a & msk;
    bm   = b & msk;
    // A borrow beyond the masked width shows up as bit top+1 of the wide difference.
    if (sub)
      wide = {1'b0, am} - {1'b0, bm} - {{DW{1'b0}}, cin};
    else
      wide = {1'b0, am} + {1'b0, bm} + {{DW{1'b0}}, cin};
    res  = wide[DW-1:0] & msk;
    tidx = top_index(width);
    cidx = {1'b0, tidx} + 6'd1;
    carry_out_top  = wide[cidx];
    // The sum bit is a ^ b ^ incoming carry, so the incoming carry can be recovered from it.
    carry_into_top = am[tidx] ^ bm[tidx] ^ res[tidx];
    if (sub)
      nib = {1'b0, a[3:0]} - {1'b0, b[3:0]} - {4'd0, cin};
    else
      nib = {1'b0, a[3:0]} + {1'b0, b[3:0]} + {4'd0, cin};
    aux_carry = nib[4];
  end

endmodule

// File: rtl/fu_flags.sv
`timescale 1ns/1ps
module fu_flags
  import flagunit_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic [DW-1:0] res,
  input  width_e        width,
  input  logic          carry_into_top,
  input  logic          carry_out_top,
  input  logic          aux_carry,
  output arith_flags_t  nxt
);

  always_comb begin
    nxt.cry = carry_out_top;
    nxt.ovf = carry_into_top ^ carry_out_top;
    nxt.sgn = res[top_index(width)];
    nxt.zer = (res == '0);
    nxt.aux = aux_carry;
    nxt.par = even_parity8(res[7:0]);
  end

endmodule

// File: rtl/fu_state.sv
`timescale 1ns/1ps
module fu_state
  import flagunit_pkg::*;
#(
  parameter int FW    = FLAG_W,
  parameter int CTL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             update,
  input  arith_flags_t     nxt,
  input  logic             ctl_we,
  input  logic [CTL_W-1:0] ctl_wdata,
  output logic [FW-1:0]    word
);

  arith_flags_t     arith_q;
  logic [CTL_W-1:0] ctl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      arith_q <= '0;
      ctl_q   <= '0;
    end else begin
      if (update) arith_q <= nxt;
      if (ctl_we) ctl_q   <= ctl_wdata;
    end
  end

  always_comb begin
    word                         = '0;
    word[ONE_POS]                = 1'b1;
    word[CF_POS]                 = arith_q.cry;
    word[PF_POS]                 = arith_q.par;
    word[AF_POS]                 = arith_q.aux;
    word[ZF_POS]                 = arith_q.zer;
    word[SF_POS]                 = arith_q.sgn;
    word[OF_POS]                 = arith_q.ovf;
    word[TF_POS+CTL_W-1:TF_POS]  = ctl_q;
  end

endmodule

// File: rtl/status_flag_unit.sv
`timescale 1ns/1ps
module status_flag_unit
  import flagunit_pkg::*;
#(
  parameter int DATA_W_P = DATA_W,
  parameter int FLAG_W_P = FLAG_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [DATA_W_P-1:0] op_a,
  input  logic [DATA_W_P-1:0] op_b,
  input  logic                carry_in,
  input  logic                sub,
  input  logic [1:0]          width_sel,
  input  logic                update,
  input  logic                ctl_we,
  input  logic [2:0]          ctl_wdata,
  output logic [DATA_W_P-1:0] result,
  output logic [FLAG_W_P-1:0] flags,
  output logic                step_dec
);

  width_e       width;
  logic         carry_into_top;
  logic         carry_out_top;
  logic         aux_carry;
  arith_flags_t nxt_flags;

  assign width = width_e'(width_sel);

  fu_arith #(.DW(DATA_W_P)) u_arith (
    .a              (op_a),
    .b              (op_b),
    .cin            (carry_in),
    .sub            (sub),
    .width          (width),
    .res            (result),
    .carry_into_top (carry_into_top),
    .carry_out_top  (carry_out_top),
    .aux_carry      (aux_carry)
  );

  fu_flags #(.DW(DATA_W_P)) u_flags (
    .res            (result),
    .width          (width),
    .carry_into_top (carry_into_top),
    .carry_out_top  (carry_out_top),
    .aux_carry      (aux_carry),
    .nxt            (nxt_flags)
  );

  fu_state #(.FW(FLAG_W_P), .CTL_W(3)) u_state (
    .clk       (clk),
    .rst       (rst),
    .update    (update),
    .nxt       (nxt_flags),
    .ctl_we    (ctl_we),
    .ctl_wdata (ctl_wdata),
    .word      (flags)
  );

  assign step_dec = flags[DIR_POS];

endmodule

// File: rtl/fu_checker.sv
`timescale 1ns/1ps
module fu_checker (
  input logic        clk,
  input logic        rst,
  input logic        update,
  input logic        ctl_we,
  input logic [2:0]  ctl_wdata,
  input logic [1:0]  width_sel,
  input logic [31:0] result,
  input logic [31:0] flags,
  input logic        carry_into_top,
  input logic        carry_out_top,
  input logic        aux_carry
);

  p_upper8_zero_r1: assert property (@(posedge clk) disable iff (rst)
    (width_sel == 2'b00) |-> (result[31:8] == 24'd0));

  p_upper16_zero_r1: assert property (@(posedge clk) disable iff (rst)
    (width_sel == 2'b01) |-> (result[31:16] == 16'd0));

  p_carry_capture_r2: assert property (@(posedge clk) disable iff (rst)
    update |=> (flags[0] == $past(carry_out_top)));

  p_overflow_capture_r3: assert property (@(posedge clk) disable iff (rst)
    update |=> (flags[11] == $past(carry_into_top ^ carry_out_top)));

  p_aux_capture_r6: assert property (@(posedge clk) disable iff (rst)
    update |=> (flags[4] == $past(aux_carry)));

  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!update && !ctl_we) |=> $stable(flags));

  p_ctl_write_r9: assert property (@(posedge clk) disable iff (rst)
    ctl_we |=> (flags[10:8] == $past(ctl_wdata)));

  p_fixed_bits_r11: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (flags[1] && flags[31:12] == 20'd0 && !flags[5] && !flags[3]));

  p_reset_value_r12: assert property (@(posedge clk)
    rst |=> (flags == 32'h0000_0002));

endmodule

bind status_flag_unit fu_checker u_chk (
  .clk            (clk),
  .rst            (rst),
  .update         (update),
  .ctl_we         (ctl_we),
  .ctl_wdata      (ctl_wdata),
  .width_sel      (width_sel),
  .result         (result),
  .flags          (flags),
  .carry_into_top (carry_into_top),
  .carry_out_top  (carry_out_top),
  .aux_carry      (aux_carry)
);

// File: tb/status_flag_unit_test.sv
`timescale 1ns/1ps
module status_flag_unit_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] op_a = '0;
  logic [31:0] op_b = '0;
  logic        carry_in = 1'b0;
  logic        sub = 1'b0;
  logic [1:0]  width_sel = 2'b10;
  logic        update = 1'b0;
  logic        ctl_we = 1'b0;
  logic [2:0]  ctl_wdata = '0;
  logic [31:0] result;
  logic [31:0] flags;
  logic        step_dec;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [31:0] word;
    string       tag;
  } exp_t;

  exp_t        sb_q[$];
  logic [31:0] model_flags = 32'h2;

  always #2.5 clk = ~clk;

  status_flag_unit uut (
    .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .carry_in(carry_in),
    .sub(sub), .width_sel(width_sel), .update(update), .ctl_we(ctl_we),
    .ctl_wdata(ctl_wdata), .result(result), .flags(flags), .step_dec(step_dec)
  );

  task automatic compare(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Driver: applies one cycle of stimulus, checks the result, queues the expected flags.
  task automatic step(bit r, bit upd, bit we, logic [2:0] cd, logic [1:0] w,
                      bit s, bit c, logic [31:0] a, logic [31:0] b, string tag);
    int          wd;
    logic [63:0] m, am, bm, rr;
    bit          cf, af, sa, sb, sr, ofl;
    exp_t        it;
    @(negedge clk);
    rst = r; update = upd; ctl_we = we; ctl_wdata = cd; width_sel = w;
    sub = s; carry_in = c; op_a = a; op_b = b;
    #1;
    wd = (w == 2'b00) ? 8 : (w == 2'b01) ? 16 : 32;
    m  = (64'd1 << wd) - 64'd1;
    am = {32'd0, a} & m;
    bm = {32'd0, b} & m;
    if (!s) begin
      rr = am + bm + 64'(c);
      cf = rr[wd];
      af = ({28'd0, a[3:0]} + {28'd0, b[3:0]} + 32'(c)) > 32'd15;
    end else begin
      rr = am - bm - 64'(c);
      cf = am < (bm + 64'(c));
      af = {28'd0, a[3:0]} < ({28'd0, b[3:0]} + 32'(c));
    end
    rr = rr & m;
    sa = am[wd-1]; sb = bm[wd-1]; sr = rr[wd-1];
    ofl = s ? (sa != sb && sr != sa) : (sa == sb && sr != sa);
    compare({tag, " result"}, result, rr[31:0]);
    if (r) model_flags = 32'h2;
    else begin
      if (upd) begin
        model_flags[0]  = cf;
        model_flags[2]  = ($countones(rr[7:0]) % 2) == 0;
        model_flags[4]  = af;
        model_flags[6]  = (rr == 64'd0);
        model_flags[7]  = sr;
        model_flags[11] = ofl;
      end
      if (we) model_flags[10:8] = cd;
    end
    it.word = model_flags;
    it.tag  = tag;
    sb_q.push_back(it);
  endtask

  // Monitor: one edge after each driven cycle, compare the registered word.
  initial begin
    exp_t it;
    forever begin
      @(posedge clk);
      #1;
      if (sb_q.size() > 0) begin
        it = sb_q.pop_front();
        compare({it.tag, " flags"}, flags, it.word);
        compare("R10 step_dec", {31'd0, step_dec}, {31'd0, it.word[10]});
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    step(1, 0, 0, 3'b000, 2'b10, 0, 0, 32'h0, 32'h0, "R12 R11 reset");
    step(1, 1, 1, 3'b111, 2'b00, 0, 0, 32'h5, 32'h7, "R12 reset wins");
    // 8-bit signed overflow, garbage in upper operand bits
    step(0, 1, 0, 3'b000, 2'b00, 0, 0, 32'hABCD_EF7F, 32'h1234_5601, "R1 R3 R4 R6 R7 add8 ovf");
    step(0, 1, 0, 3'b000, 2'b00, 0, 0, 32'hFFFF_FFFF, 32'h0000_0001, "R1 R2 R5 R7 add8 wrap");
    step(0, 1, 0, 3'b000, 2'b01, 1, 0, 32'hFFFF_0000, 32'h0000_0001, "R1 R2 R4 R6 sub16 borrow");
    step(0, 1, 0, 3'b000, 2'b10, 1, 0, 32'h8000_0000, 32'h0000_0001, "R3 sub32 ovf");
    step(0, 1, 0, 3'b000, 2'b10, 0, 1, 32'hFFFF_FFFF, 32'h0000_0000, "R1 R2 R5 add32 carry_in");
    step(0, 1, 0, 3'b000, 2'b01, 0, 0, 32'h0000_00FF, 32'h0000_0001, "R6 R7 add16 low-byte flags");
    step(0, 1, 0, 3'b000, 2'b00, 1, 1, 32'h0000_0010, 32'h0000_000F, "R5 R6 sub8 with borrow");
    step(0, 1, 0, 3'b000, 2'b11, 0, 0, 32'h7FFF_FFFF, 32'h0000_0001, "R1 R3 width code 11");
    step(0, 0, 0, 3'b000, 2'b00, 0, 0, 32'h0000_00FF, 32'h0000_0001, "R8 hold");
    step(0, 0, 0, 3'b000, 2'b10, 1, 1, 32'h0, 32'h1, "R8 hold again");
    step(0, 1, 1, 3'b101, 2'b00, 0, 0, 32'h0000_0080, 32'h0000_0080, "R9 R10 update with ctl write");
    step(0, 0, 1, 3'b010, 2'b10, 0, 0, 32'h1, 32'h1, "R9 R10 ctl write only");
    step(0, 0, 0, 3'b000, 2'b10, 0, 0, 32'h1, 32'h1, "R8 R11 idle");
    for (int i = 0; i < 400; i++) begin
      logic [31:0] ra, rb;
      logic [3:0]  ctl;
      ra  = $urandom();
      rb  = $urandom();
      ctl = 4'($urandom());
      if (i % 7 == 0) rb = ra;
      step(0, ($urandom() % 4) != 0, ctl[3], ctl[2:0], 2'($urandom()),
           1'($urandom()), 1'($urandom()), ra, rb, "R1 R2 R3 R4 R5 R6 R7 R9 random");
    end
    step(1, 0, 0, 3'b000, 2'b10, 0, 0, 32'h0, 32'h0, "R12 reset after run");
    repeat (3) @(posedge clk);
    #2;
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule